// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects 32 level-sensitive interrupt requests and presents them to a processor on two outputs: a fast request line and a normal request line. Each request is the OR of an external source and a software trigger. It passes only when its mask bit is on, and a per-source routing bit sends it to one line or the other. Software programs the block over a simple APB-style register bus. The mask and the software triggers each have a write-ones-to-set register and a separate write-ones-to-clear register, so no read-modify-write is needed.

Normal requests can be bound to 16 vector slots. Each slot names one source and holds a handler address, and the slot index is its priority (slot 0 wins). A normal request that no enabled slot claims uses the default handler address. Reading the vector register returns the handler address of the winning request and enters service at that priority. The current level is pushed onto a 17-entry stack. While it is in service, the normal line ignores that level and every lower one. Writing any value to the vector register ends service and pops the previous level.

A protection bit can restrict register writes to privileged bus cycles. Four identification registers give a 32-bit cell ID one byte at a time.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Raw status (offset 0x008) reads `src_i | soft`. Every source is level-sensitive, so dropping a source removes its request on the next read, with no latching.
- R2: Writing ones to offset 0x010 sets mask bits, and writing ones to offset 0x014 clears them. Zero bits leave the mask unchanged. The mask reads back at 0x010. The normal masked status at 0x000 reads `raw & mask & ~route`.
- R3: Writing ones to offset 0x018 sets software triggers, and writing ones to offset 0x01C clears them. The triggers read back at 0x018.
- R4: The route register (0x00C) sends an enabled, active source to `fast_irq` when its bit is 1 and to the normal path when its bit is 0. The fast masked status reads at 0x004.
- R5: Vector slot i has its handler address at 0x100+4i and its control at 0x200+4i. In the control word, bit 5 enables the slot and bits 4:0 select the source. When several slots are active, the lowest-numbered enabled slot wins.
- R6: An active normal request that no enabled slot claims reads the default address (0x034) from the vector register (0x030).
- R7: A read of 0x030 while `norm_irq` is high enters service at the winning level. After that, `norm_irq` ignores that level and every lower one, while higher-priority slots still assert it. A write to 0x030 restores the previous level.
- R8: Service nests 17 levels deep (16 slots plus the default), and 17 end-of-service writes unwind it fully. A write to 0x030 with nothing in service has no effect.
- R9: Offsets 0xFE0, 0xFE4, 0xFE8 and 0xFEC return bytes 0 to 3 of the `CELL_ID` parameter in bits 7:0, least significant byte first. The vendor code sits in bits 19:12 of the assembled ID.
- R10: When the protect bit (0x020, bit 0) is set, any write with `priv_i` low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write when high |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| priv_i | input | 1 | Privileged bus cycle |
| prdata | output | 32 | Read data, valid in the access phase |
| src_i | input | 32 | Level interrupt sources |
| norm_irq | output | 1 | Normal interrupt request |
| fast_irq | output | 1 | Fast interrupt request |

## Verification
The embedded assertions check the following on every cycle:
- An acknowledge always moves service to a strictly higher priority.
- A finish always returns to a strictly lower priority.
- The nesting pointer never passes its depth.
- A clear write leaves the cleared mask bits at zero.
- A blocked unprivileged write leaves the mask and route registers unchanged.
- A fast request never appears without a routed, enabled source.

Only the directed scenarios can show the rest:
- which handler address is returned for a given mix of slots
- that the default address applies to unclaimed sources
- that a full 17-level nest unwinds to the idle state
- the cell ID byte order

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int NSLOT = 16,
  parameter logic [31:0] CELL_ID = 32'h1357_9BDF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [11:0] paddr,
  input  logic [31:0] pwdata,
  input  logic        priv_i,
  output logic [31:0] prdata,
  input  logic [31:0] src_i,
  output logic        norm_irq,
  output logic        fast_irq
);
  localparam int DEPTH = NSLOT + 1;
  localparam int LW = $clog2(NSLOT + 2);
  localparam int PW = $clog2(DEPTH + 1);
  localparam logic [LW-1:0] DEF_LVL = LW'(NSLOT);
  localparam logic [LW-1:0] IDLE = LW'(NSLOT + 1);

  logic [31:0] en_q, soft_q, sel_q, def_q;
  logic        prot_q;
  logic [31:0] vadr_q [NSLOT];
  logic [5:0]  vctl_q [NSLOT];
  logic [LW-1:0] cur_q;
  logic [LW-1:0] stk_q [DEPTH];
  logic [PW-1:0] sp_q;

  wire acc   = psel & penable;
  wire wr_ok = acc & pwrite & (~prot_q | priv_i);
  wire rd    = acc & ~pwrite;
  wire [31:0] raw   = src_i | soft_q;
  wire [31:0] act_n = raw & en_q & ~sel_q;
  wire [31:0] act_f = raw & en_q & sel_q;

  logic [LW-1:0] best;
  logic [31:0]   best_adr, claimed;
  always_comb begin
    best = IDLE;
    best_adr = def_q;
    claimed = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (vctl_q[i][5]) begin
        claimed[vctl_q[i][4:0]] = 1'b1;
        if (act_n[vctl_q[i][4:0]]) begin
          best = LW'(i);
          best_adr = vadr_q[i];
        end
      end
    end
    if (best == IDLE && |(act_n & ~claimed)) best = DEF_LVL;
  end

  assign norm_irq = best < cur_q;
  assign fast_irq = |act_f;

  wire ack    = rd && paddr == 12'h030 && norm_irq;
  wire finish = wr_ok && paddr == 12'h030;

  always_comb begin
    prdata = '0;
    case (paddr)
      12'h000: prdata = act_n;
      12'h004: prdata = act_f;
      12'h008: prdata = raw;
      12'h00C: prdata = sel_q;
      12'h010: prdata = en_q;
      12'h018: prdata = soft_q;
      12'h020: prdata = {31'd0, prot_q};
      12'h030: prdata = norm_irq ? best_adr : def_q;
      12'h034: prdata = def_q;
      12'hFE0: prdata = {24'd0, CELL_ID[7:0]};
      12'hFE4: prdata = {24'd0, CELL_ID[15:8]};
      12'hFE8: prdata = {24'd0, CELL_ID[23:16]};
      12'hFEC: prdata = {24'd0, CELL_ID[31:24]};
      default: begin
        for (int i = 0; i < NSLOT; i++) begin
          if (paddr == 12'(12'h100 + 4 * i)) prdata = vadr_q[i];
          if (paddr == 12'(12'h200 + 4 * i)) prdata = {26'd0, vctl_q[i]};
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0; soft_q <= '0; sel_q <= '0; def_q <= '0; prot_q <= 1'b0;
      for (int i = 0; i < NSLOT; i++) begin
        vadr_q[i] <= '0;
        vctl_q[i] <= '0;
      end
    end else if (wr_ok) begin
      case (paddr)
        12'h00C: sel_q <= pwdata;
        12'h010: en_q <= en_q | pwdata;
        12'h014: en_q <= en_q & ~pwdata;
        12'h018: soft_q <= soft_q | pwdata;
        12'h01C: soft_q <= soft_q & ~pwdata;
        12'h020: prot_q <= pwdata[0];
        12'h034: def_q <= pwdata;
        default: begin
          for (int i = 0; i < NSLOT; i++) begin
            if (paddr == 12'(12'h100 + 4 * i)) vadr_q[i] <= pwdata;
            if (paddr == 12'(12'h200 + 4 * i)) vctl_q[i] <= pwdata[5:0];
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= IDLE;
      sp_q <= '0;
      for (int i = 0; i < DEPTH; i++) stk_q[i] <= IDLE;
    end else if (ack) begin
      stk_q[sp_q] <= cur_q;
      sp_q <= sp_q + PW'(1);
      cur_q <= best;
    end else if (finish && sp_q != '0) begin
      cur_q <= stk_q[sp_q - PW'(1)];
      sp_q <= sp_q - PW'(1);
    end
  end

  p_ack_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> cur_q < $past(cur_q));
  p_finish_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && sp_q != '0) |=> cur_q > $past(cur_q));
  p_depth_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q <= PW'(DEPTH));
  p_mask_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && paddr == 12'h014) |=> (en_q & $past(pwdata)) == '0);
  p_protect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && pwrite && prot_q && !priv_i) |=> $stable(en_q) && $stable(sel_q));
  p_fast_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fast_irq |-> |(en_q & sel_q));
endmodule

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
  localparam logic [31:0] ID = 32'h1357_9BDF;
  logic clk = 0, rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0, priv_i = 1;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata, src_i = '0;
  logic norm_irq, fast_irq;
  int errors = 0, checks = 0;
  bit done = 0;

  irq_vector_ctrl #(.NSLOT(16), .CELL_ID(ID)) uut (.*);

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic pv = 1);
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d; priv_i = pv;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0; priv_i = 1;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic src(input logic [31:0] s);
    @(negedge clk); src_i = s; #1;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("reset norm_irq", 32'(norm_irq), 0);
    chk("reset fast_irq", 32'(fast_irq), 0);
    rd(12'h010, d); chk("reset mask", d, 0);
  endtask

  task automatic t_level_r1;
    logic [31:0] d;
    src(32'h11);
    rd(12'h008, d); chk("R1 raw", d, 32'h11);
    chk("R1 masked norm", 32'(norm_irq), 0);
    src(0);
    rd(12'h008, d); chk("R1 level drop", d, 0);
  endtask

  task automatic t_mask_r2;
    logic [31:0] d;
    src(32'h1);
    wr(12'h010, 32'h1); rd(12'h010, d); chk("R2 set", d, 32'h1);
    rd(12'h000, d); chk("R2 norm status", d, 32'h1);
    chk("R2 norm_irq", 32'(norm_irq), 1);
    wr(12'h010, 32'h10); wr(12'h014, 32'h1);
    rd(12'h010, d); chk("R2 zero bits kept", d, 32'h10);
    #1 chk("R2 cleared norm_irq", 32'(norm_irq), 0);
    wr(12'h014, 32'hFFFF_FFFF); src(0);
  endtask

  task automatic t_soft_r3;
    logic [31:0] d;
    wr(12'h018, 32'h100); rd(12'h018, d); chk("R3 soft set", d, 32'h100);
    rd(12'h008, d); chk("R3 raw soft", d, 32'h100);
    wr(12'h01C, 32'h100); rd(12'h008, d); chk("R3 soft clear", d, 0);
  endtask

  task automatic t_route_r4;
    logic [31:0] d;
    wr(12'h010, 32'h200); wr(12'h018, 32'h200); wr(12'h00C, 32'h200);
    #1 chk("R4 fast", 32'(fast_irq), 1);
    chk("R4 no norm", 32'(norm_irq), 0);
    rd(12'h004, d); chk("R4 fast status", d, 32'h200);
    wr(12'h00C, 0);
    #1 chk("R4 back to norm", 32'(norm_irq), 1);
    chk("R4 fast off", 32'(fast_irq), 0);
    wr(12'h01C, 32'hFFFF_FFFF); wr(12'h014, 32'hFFFF_FFFF);
  endtask

  task automatic t_prio_r5_r6_r7;
    logic [31:0] d;
    wr(12'h010, 32'hFFFF_FFFF); wr(12'h034, 32'hDEF0);
    wr(12'h100, 32'hA000); wr(12'h200, 32'h23);
    wr(12'h114, 32'hA500); wr(12'h214, 32'h27);
    src(32'h88);
    rd(12'h030, d); chk("R5 lowest slot wins", d, 32'hA000);
    wr(12'h030, 0); src(0);
    src(32'h1000);
    rd(12'h030, d); chk("R6 default address", d, 32'hDEF0);
    wr(12'h030, 0); src(0);
    src(32'h80);
    rd(12'h030, d); chk("R7 ack slot5", d, 32'hA500);
    chk("R7 same level masked", 32'(norm_irq), 0);
    src(32'h1080); chk("R7 lower masked", 32'(norm_irq), 0);
    src(32'h1088); chk("R7 higher passes", 32'(norm_irq), 1);
    rd(12'h030, d); chk("R7 nested ack", d, 32'hA000);
    src(32'h1080); chk("R7 in slot0", 32'(norm_irq), 0);
    wr(12'h030, 0); #1 chk("R7 back to slot5", 32'(norm_irq), 0);
    wr(12'h030, 0); #1 chk("R7 idle again", 32'(norm_irq), 1);
    src(0);
  endtask

  task automatic t_nest_r8;
    logic [31:0] d;
    for (int i = 0; i < 16; i++) begin
      wr(12'(12'h100 + 4 * i), 32'h1000 + 32'(i) * 16);
      wr(12'(12'h200 + 4 * i), 32'h20 | 32'(i));
    end
    wr(12'h030, 0);
    src(32'h0010_0000);
    rd(12'h030, d); chk("R8 default level", d, 32'hDEF0);
    src(0);
    for (int j = 15; j >= 0; j--) begin
      src(32'h1 << j);
      rd(12'h030, d); chk("R8 nested slot", d, 32'h1000 + 32'(j) * 16);
      src(0);
    end
    for (int k = 0; k < 16; k++) wr(12'h030, 0);
    src(32'h0010_0000);
    chk("R8 default still in service", 32'(norm_irq), 0);
    wr(12'h030, 0); #1 chk("R8 fully unwound", 32'(norm_irq), 1);
    src(0);
  endtask

  task automatic t_id_r9;
    logic [31:0] d, idv;
    idv = 0;
    for (int i = 0; i < 4; i++) begin
      rd(12'(12'hFE0 + 4 * i), d);
      chk("R9 byte upper zero", d & 32'hFFFF_FF00, 0);
      idv |= (d & 32'hFF) << (8 * i);
    end
    chk("R9 cell id", idv, ID);
    chk("R9 vendor", (idv >> 12) & 32'hFF, 32'h79);
  endtask

  task automatic t_prot_r10;
    logic [31:0] d;
    wr(12'h014, 32'hFFFF_FFFF);
    wr(12'h020, 1);
    wr(12'h010, 32'h4, 0);
    rd(12'h010, d); chk("R10 unprivileged ignored", d, 0);
    wr(12'h010, 32'h4, 1);
    rd(12'h010, d); chk("R10 privileged accepted", d, 32'h4);
    wr(12'h020, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 t_reset;
    t_level_r1;
    t_mask_r2;
    t_soft_r3;
    t_route_r4;
    t_prio_r5_r6_r7;
    t_nest_r8;
    t_id_r9;
    t_prot_r10;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule